// File: doc/BRIEF.md
# HDB3 Bipolar Line Encoder

This block turns a unipolar NRZ bit stream into the two pulse rails that drive a bipolar line interface. One input bit enters per clock cycle. Each one becomes a pulse on the positive rail or on the negative rail. Each zero becomes an empty slot. In HDB3 mode, a run of four zeros is never sent as it stands. It goes out as a three-zero pattern that ends in a polarity violation, or as a bipolar pulse, two zeros and a violation. This keeps transitions on the line for the receiver's clock recovery.

The input passes through a short delay line, so a complete group of four zeros can be seen before its first slot reaches the rails. The encoder chooses the group's pattern from the parity of the pulses sent since the last violation. That choice keeps the number of pulses between two violations odd, so the line stays free of DC. A mode input switches to plain alternate-mark inversion, where zeros are never replaced. The output drives the line-driver pins directly. Pulse shaping and clocking are handled elsewhere.

Top module: `hdb3_line_encoder`

## Requirements
- R1: While reset is asserted and right after it, both rails are low. The remembered polarity is negative, so the first non-violation pulse after reset appears on the positive rail.
- R2: The slot for the input bit sampled at clock edge k appears on the rails after edge k+4. In HDB3 mode a one always produces a pulse in that slot.
- R3: Outside substitution groups, each one is sent as a pulse of the polarity opposite to the previous pulse, and each zero is sent as no pulse.
- R4: posOut and negOut are never high in the same cycle.
- R5: In HDB3 mode (amiMode = 0), the rails never show four consecutive empty slots among bits that entered in HDB3 mode.
- R6: A violation pulse has the same polarity as the pulse just before it. It occupies only the last slot of a four-zero group, so it follows two or three empty slots.
- R7: If an odd number of pulses have been sent since the last violation (or since reset), a four-zero group goes out as 000V. If the number is even, the group goes out as B00V, where B is a normally alternating pulse in the group's first slot. As a result, the number of pulses between two successive violations is always odd.
- R8: With amiMode = 1, no zero is replaced. A slot carries a pulse exactly when its input bit was a one, and no violation is sent.
- R9: Zero groups do not overlap. The count of zeros restarts after every one and after every substitution, so eight consecutive zeros are sent as two complete substitution groups.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock, rising edge active |
| rstN | input | 1 | Asynchronous active-low reset |
| dataIn | input | 1 | Unipolar NRZ data bit, one per cycle |
| amiMode | input | 1 | 1 selects plain AMI, 0 selects HDB3 substitution |
| posOut | output | 1 | Positive-polarity pulse rail |
| negOut | output | 1 | Negative-polarity pulse rail |

## Verification
The assertions check on every cycle that the rails are exclusive and that ones surface as pulses after four cycles. They also check that a violation only closes a zero group and comes after an odd number of pulses, that no fourth empty slot follows three in HDB3 mode, and that AMI mode passes bits through unchanged. Some properties can only be shown by the bench's bit patterns with known expected rail sequences. These are the exact choice between 000V and B00V, the exact polarity of each B and V pulse, the split of long zero runs into separate groups, and the polarity restart after a reset in the middle of a stream.

// File: rtl/hdb3_enc_pkg.sv
package hdb3_enc_pkg;

  // One line slot travelling through the delay line
  typedef struct packed {
    logic pulse;   // slot carries a mark (data one, B or V)
    logic viol;    // mark must repeat the previous polarity
  } lineSym_t;

  // Strobes from the control to the datapath
  typedef struct packed {
    logic tagViol; // incoming zero closes a group: send it as V
    logic tagBip;  // first slot of that group becomes a B pulse
  } ctrlStrobe_t;

endpackage

// File: rtl/hdb3_ctrl.sv
module hdb3_ctrl
  import hdb3_enc_pkg::*;
#(
  parameter int ZERO_RUN = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        dataIn,
  input  logic        amiMode,
  input  lineSym_t    leadSym,
  output ctrlStrobe_t strobes
);

  localparam int CNT_W = (ZERO_RUN > 2) ? $clog2(ZERO_RUN) : 1;
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(ZERO_RUN - 1);

  logic [CNT_W-1:0] runCnt;
  logic             pulseParity;   // pulses since last V, modulo 2
  logic             parityAhead;   // parity once leadSym is on the line
  logic             substNow;

  // The slot leaving the delay line this cycle is the one just before the
  // candidate group, so it is folded into the parity used for the choice.
  always_comb begin
    if (leadSym.pulse && leadSym.viol) parityAhead = 1'b0;
    else                               parityAhead = pulseParity ^ leadSym.pulse;
  end

  assign substNow = !amiMode && !dataIn && (runCnt == LAST_CNT);

  always_comb begin
    strobes.tagViol = substNow;
    strobes.tagBip  = substNow && !parityAhead;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runCnt      <= '0;
      pulseParity <= 1'b0;
    end else begin
      if (amiMode || dataIn || substNow) runCnt <= '0;
      else                               runCnt <= runCnt + 1'b1;
      pulseParity <= parityAhead;
    end
  end

endmodule

// File: rtl/hdb3_datapath.sv
module hdb3_datapath
  import hdb3_enc_pkg::*;
#(
  parameter int ZERO_RUN = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        dataIn,
  input  ctrlStrobe_t strobes,
  output lineSym_t    leadSym,
  output logic        posOut,
  output logic        negOut
);

  localparam int LAST = ZERO_RUN - 1;

  lineSym_t stage [ZERO_RUN];
  logic     lastPos;   // 1: last pulse was positive
  logic     nextPos;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stage[0] <= '0;
    else       stage[0] <= '{pulse: dataIn | strobes.tagViol, viol: strobes.tagViol};
  end

  for (genvar j = 1; j < ZERO_RUN; j++) begin : gStage
    if (j == LAST) begin : gHead
      // The group's first zero enters the last stage as it is tagged
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stage[j] <= '0;
        else       stage[j] <= '{pulse: stage[j-1].pulse | strobes.tagBip,
                                 viol:  stage[j-1].viol};
      end
    end else begin : gBody
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stage[j] <= '0;
        else       stage[j] <= stage[j-1];
      end
    end
  end

  assign leadSym = stage[LAST];

  always_comb begin
    if (leadSym.viol) nextPos = lastPos;
    else              nextPos = !lastPos;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lastPos <= 1'b0;
      posOut  <= 1'b0;
      negOut  <= 1'b0;
    end else begin
      posOut <= leadSym.pulse &&  nextPos;
      negOut <= leadSym.pulse && !nextPos;
      if (leadSym.pulse) lastPos <= nextPos;
    end
  end

endmodule

// File: rtl/hdb3_line_encoder.sv
module hdb3_line_encoder
  import hdb3_enc_pkg::*;
#(
  parameter int ZERO_RUN = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic dataIn,
  input  logic amiMode,
  output logic posOut,
  output logic negOut
);

  ctrlStrobe_t strobes;
  lineSym_t    leadSym;

  hdb3_ctrl #(.ZERO_RUN(ZERO_RUN)) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .dataIn  (dataIn),
    .amiMode (amiMode),
    .leadSym (leadSym),
    .strobes (strobes)
  );

  hdb3_datapath #(.ZERO_RUN(ZERO_RUN)) uPath (
    .clk     (clk),
    .rstN    (rstN),
    .dataIn  (dataIn),
    .strobes (strobes),
    .leadSym (leadSym),
    .posOut  (posOut),
    .negOut  (negOut)
  );

endmodule

// File: rtl/hdb3_line_encoder_chk.sv
module hdb3_line_encoder_chk #(
  parameter int ZERO_RUN = 4
) (
  input logic clk,
  input logic rstN,
  input logic dataIn,
  input logic amiMode,
  input logic posOut,
  input logic negOut
);

  localparam int D   = ZERO_RUN;
  localparam int CW  = $clog2(ZERO_RUN + 1) + 1;
  localparam logic [CW-1:0] SAT = CW'(ZERO_RUN);

  logic          dataDly [D+1];
  logic          amiDly  [D+1];
  logic          lastPosC;
  logic          pulsesOdd;
  logic [CW-1:0] zeroRun;
  logic [CW-1:0] hdbZeros;
  logic          pulse;
  logic          isViol;

  assign pulse  = posOut | negOut;
  assign isViol = pulse && (posOut == lastPosC);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i <= D; i++) begin
        dataDly[i] <= 1'b0;
        amiDly[i]  <= 1'b1;
      end
      lastPosC  <= 1'b0;
      pulsesOdd <= 1'b0;
      zeroRun   <= '0;
      hdbZeros  <= '0;
    end else begin
      dataDly[0] <= dataIn;
      amiDly[0]  <= amiMode;
      for (int i = 1; i <= D; i++) begin
        dataDly[i] <= dataDly[i-1];
        amiDly[i]  <= amiDly[i-1];
      end
      if (pulse) begin
        lastPosC  <= posOut;
        pulsesOdd <= isViol ? 1'b0 : !pulsesOdd;
        zeroRun   <= '0;
      end else if (zeroRun != SAT) begin
        zeroRun <= zeroRun + 1'b1;
      end
      if (pulse || amiDly[D])   hdbZeros <= '0;
      else if (hdbZeros != SAT) hdbZeros <= hdbZeros + 1'b1;
    end
  end

  AST_RAILS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(posOut && negOut)) else $error("rails both high"); // R4

  AST_ONE_BECOMES_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    (!amiDly[D] && dataDly[D]) |-> pulse) else $error("one lost"); // R2

  AST_V_CLOSES_GROUP: assert property (@(posedge clk) disable iff (!rstN)
    isViol |-> (zeroRun >= CW'(ZERO_RUN - 2))) else $error("stray violation"); // R6

  AST_ODD_PULSES_BEFORE_V: assert property (@(posedge clk) disable iff (!rstN)
    isViol |-> pulsesOdd) else $error("even pulse count between violations"); // R7

  AST_NO_LONG_ZERO_RUN: assert property (@(posedge clk) disable iff (!rstN)
    (!amiDly[D] && (hdbZeros == CW'(ZERO_RUN - 1))) |-> pulse)
    else $error("zero run too long"); // R5

  AST_AMI_PASSTHROUGH: assert property (@(posedge clk) disable iff (!rstN)
    amiDly[D] |-> (pulse == dataDly[D])) else $error("ami slot altered"); // R8

  AST_AMI_NO_VIOLATION: assert property (@(posedge clk) disable iff (!rstN)
    (amiDly[D] && pulse) |-> !isViol) else $error("violation in ami"); // R8

endmodule

bind hdb3_line_encoder hdb3_line_encoder_chk #(.ZERO_RUN(ZERO_RUN)) uChk (
  .clk     (clk),
  .rstN    (rstN),
  .dataIn  (dataIn),
  .amiMode (amiMode),
  .posOut  (posOut),
  .negOut  (negOut)
);

// File: tb/tb_hdb3_line_encoder.sv
`timescale 1ns/1ps
module tb_hdb3_line_encoder;

  localparam int NB = 16;

  typedef struct packed {
    logic          ami;
    logic [NB-1:0] bits;  // bit i is sent in slot i
    logic [NB-1:0] pos;
    logic [NB-1:0] neg;
    logic [3:0]    req;
  } vec_t;

  // Expected rails derived by hand from the requirements (reset state:
  // last polarity negative, zero pulses since last violation)
  localparam vec_t VECS [6] = '{
    // R7: 000V after odd pulse counts (V at slots 7 and 12)
    '{1'b0, 16'b1000_0001_0000_1011, 16'b1000_0000_1000_1001, 16'b0001_0001_0000_0010, 4'd7},
    // R9: leading zeros form two back-to-back B00V groups, then one more
    '{1'b0, 16'b1000_0011_0000_0000, 16'b0010_0101_0000_1001, 16'b1000_0010_1001_0000, 4'd9},
    // R8: AMI mode, five zeros left as they are
    '{1'b1, 16'b1101_0000_1100_0001, 16'b0100_0000_1000_0001, 16'b1001_0000_0100_0000, 4'd8},
    // R5: twelve zeros become 000V, B00V, B00V
    '{1'b0, 16'b1100_0000_0000_0001, 16'b1001_0010_0001_0001, 16'b0100_0001_0010_0000, 4'd5},
    // R3: all ones alternate, starting positive
    '{1'b0, 16'hFFFF,                16'h5555,                16'hAAAA,                4'd3},
    // R6: B00V then 000V, V repeating the preceding polarity
    '{1'b0, 16'b1000_1000_0100_0011, 16'b0000_1000_0010_0101, 16'b1000_0100_0100_0010, 4'd6}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic dataIn = 1'b0;
  logic amiMode = 1'b0;
  logic posOut, negOut;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;

  hdb3_line_encoder dut (
    .clk     (clk),
    .rstN    (rstN),
    .dataIn  (dataIn),
    .amiMode (amiMode),
    .posOut  (posOut),
    .negOut  (negOut)
  );

  task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: {pos,neg} actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic doReset(input logic mode);
    @(negedge clk);
    rstN    = 1'b0;
    dataIn  = 1'b1;
    amiMode = mode;
    repeat (3) @(negedge clk);
    check("R1", {posOut, negOut}, 2'b00);
    dataIn = 1'b0;
    rstN   = 1'b1;
  endtask

  task automatic runVec(input vec_t v);
    string tag;
    tag = $sformatf("R%0d", v.req);
    doReset(v.ami);
    for (int c = 0; c <= NB + 4; c++) begin
      if (c >= 5) begin
        check(tag, {posOut, negOut}, {v.pos[c-5], v.neg[c-5]});
        check("R4", {1'b0, posOut && negOut}, 2'b00);
      end
      dataIn = (c < NB) ? v.bits[c] : 1'b0;
      @(negedge clk);
    end
  endtask

  initial begin
    for (int k = 0; k < 6; k++) runVec(VECS[k]);

    // R2: a lone one shows up exactly four edges after it is sampled
    doReset(1'b0);
    dataIn = 1'b1;
    @(negedge clk);
    dataIn = 1'b0;
    for (int c = 1; c <= 4; c++) begin
      check("R2", {posOut, negOut}, 2'b00);
      @(negedge clk);
    end
    check("R2", {posOut, negOut}, 2'b10);

    // R1: reset in mid-stream restores the negative polarity memory
    @(negedge clk);
    dataIn = 1'b1;
    @(negedge clk);
    dataIn = 1'b0;
    repeat (6) @(negedge clk);
    doReset(1'b0);
    dataIn = 1'b1;
    @(negedge clk);
    dataIn = 1'b0;
    repeat (3) @(negedge clk);
    check("R1", {posOut, negOut}, 2'b00);
    @(negedge clk);
    check("R1", {posOut, negOut}, 2'b10);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog (all requirements): run did not finish, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

endmodule